// File: doc/BRIEF.md
# Precise External Interrupt Sequencer

This block sits between instruction dispatch and instruction fetch. It turns a level-sensitive external interrupt request into a precise exception entry. When the request is present and the machine-state enable bit is set, the block first holds off dispatch. It then waits until the completion buffer reports empty and no higher-priority exception is outstanding. This lets every instruction already in flight retire, or take its own exception, before the external one wins.

Once the drain is complete, the block raises a one-cycle take strobe. In that same cycle it presents the vector fetch address: offset 0x500 above a base chosen by the machine-state vector-prefix bit. Prefix 0 selects base 0x00000000 and prefix 1 selects base 0xFFF00000. If the request goes away or the enable bit clears before entry, the stall is released and nothing is taken. A request that stays high is resumed later, once the enable bit is set again.

Top module: `eis_ext_irq_seq`

## Requirements
- R1: After reset, dispatch_stall and take_strobe are both 0.
- R2: With the block idle, irq_req=1 and msr_ee=1 sampled at a clock edge raise dispatch_stall after that edge, with take_strobe still 0.
- R3: take_strobe is 1 only when, at the previous edge, dispatch_stall=1, irq_req=1, msr_ee=1, cb_empty=1 and hp_exc_pending=0.
- R4: hp_exc_pending=1 at an edge keeps take_strobe at 0 after that edge, so a higher-priority exception delays entry.
- R5: msr_ee=0 at an edge keeps take_strobe at 0 after it. While draining, it also releases dispatch_stall. A request that is still high is resumed once msr_ee returns to 1.
- R6: If irq_req is 0 at an edge while draining (stall=1, take=0), dispatch_stall and take_strobe are both 0 after that edge.
- R7: take_strobe never stays high for two consecutive cycles.
- R8: dispatch_stall is 1 during the take cycle and 0 in the cycle after it.
- R9: During the take cycle, redirect_addr is 0x00000500 when msr_ip was 0 at the deciding edge, and 0xFFF00500 when it was 1.
- R10: While draining with irq_req=1, msr_ee=1 and cb_empty=0 at an edge, dispatch_stall remains 1 and take_strobe remains 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level-sensitive external interrupt request |
| msr_ee | input | 1 | Machine-state external interrupt enable |
| msr_ip | input | 1 | Machine-state vector-prefix select |
| cb_empty | input | 1 | Completion buffer holds no instructions |
| hp_exc_pending | input | 1 | A higher-priority exception is outstanding |
| dispatch_stall | output | 1 | Hold new instruction dispatch |
| take_strobe | output | 1 | One-cycle exception-entry pulse |
| redirect_addr | output | 32 | Vector fetch address, valid with take_strobe |

## Verification
The assertions assume that the inputs are stable across each rising edge, and that cb_empty and hp_exc_pending may change in any cycle, including while dispatch is stalled. They make no assumption that the request is held or that the enable bit stays set. The stimulus changes every input only on the falling clock edge. It toggles the request and the vector prefix with low probability, so that many drains run to completion and many are abandoned. It also pulses the enable bit and the higher-priority flag at random during drains, so that the delay and abandonment paths are both exercised.

// File: rtl/eis_pkg.sv
package eis_pkg;

   typedef enum logic [1:0] {
      EIS_IDLE  = 2'd0,
      EIS_DRAIN = 2'd1,
      EIS_TAKE  = 2'd2
   } eis_state_e;

   function automatic int unsigned eis_cnt_width(input int unsigned hold);
      return (hold < 2) ? 1 : $clog2(hold + 1);
   endfunction

endpackage

// File: rtl/eis_drain_qual.sv
module eis_drain_qual #(
   parameter int unsigned EMPTY_HOLD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic draining,
   input  logic cb_empty,
   input  logic hp_exc_pending,
   output logic ready
);
   import eis_pkg::*;

   localparam int unsigned CW = eis_cnt_width(EMPTY_HOLD);
   localparam logic [CW-1:0] CNT_MAX = CW'(EMPTY_HOLD);
   localparam logic [CW-1:0] CNT_NEED = CW'(EMPTY_HOLD - 1);

   generate
      if (EMPTY_HOLD < 1) begin : g_bad_hold
         $error("eis_drain_qual: EMPTY_HOLD must be at least 1");
      end
   endgenerate

   logic          quiet;
   logic [CW-1:0] cnt_q;

   assign quiet = cb_empty && !hp_exc_pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!draining || !quiet) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready = quiet && (cnt_q >= CNT_NEED);

   // A pending higher-priority exception must never let the drain look finished.
   assert_hp_blocks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hp_exc_pending |-> !ready);

endmodule

// File: rtl/eis_ctrl_fsm.sv
module eis_ctrl_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic req_live,
   input  logic ready,
   input  logic cb_empty,
   output logic draining,
   output logic load_vec,
   output logic stall,
   output logic take
);
   import eis_pkg::*;

   eis_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         EIS_IDLE:  if (req_live) state_d = EIS_DRAIN;
         EIS_DRAIN: begin
            if (!req_live)  state_d = EIS_IDLE;
            else if (ready) state_d = EIS_TAKE;
         end
         EIS_TAKE:  state_d = EIS_IDLE;
         default:   state_d = EIS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= EIS_IDLE;
      else        state_q <= state_d;
   end

   assign draining = (state_q == EIS_DRAIN);
   assign load_vec = draining && req_live && ready;
   assign stall    = (state_q != EIS_IDLE);
   assign take     = (state_q == EIS_TAKE);

   assert_one_cycle_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   assert_stall_in_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> stall);

   assert_release_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !stall);

   assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !take && req_live && !cb_empty) |=> (stall && !take));

   assert_abandon_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !take && !req_live) |=> (!stall && !take));

endmodule

// File: rtl/eis_vector_gen.sv
module eis_vector_gen #(
   parameter int unsigned           ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]     LOW_BASE   = '0,
   parameter logic [ADDR_W-1:0]     HIGH_BASE  = '1,
   parameter logic [ADDR_W-1:0]     VEC_OFFSET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              msr_ip,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam bit DISJOINT = ((LOW_BASE & VEC_OFFSET) == '0) &&
                             ((HIGH_BASE & VEC_OFFSET) == '0);

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("eis_vector_gen: ADDR_W must be at least 16");
      end
   endgenerate

   logic [ADDR_W-1:0] base_sel;
   logic [ADDR_W-1:0] vec_next;
   logic [ADDR_W-1:0] vec_q;

   assign base_sel = msr_ip ? HIGH_BASE : LOW_BASE;

   generate
      if (DISJOINT) begin : g_merge_or
         assign vec_next = base_sel | VEC_OFFSET;
      end else begin : g_merge_add
         assign vec_next = base_sel + VEC_OFFSET;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    vec_q <= '0;
      else if (load) vec_q <= vec_next;
   end

   assign vec_addr = vec_q;

   assert_vec_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(vec_q));

endmodule

// File: rtl/eis_ext_irq_seq.sv
module eis_ext_irq_seq #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       EMPTY_HOLD = 1,
   parameter logic [ADDR_W-1:0] LOW_BASE   = 32'h0000_0000,
   parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFFF0_0000,
   parameter logic [ADDR_W-1:0] VEC_OFFSET = 32'h0000_0500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              msr_ee,
   input  logic              msr_ip,
   input  logic              cb_empty,
   input  logic              hp_exc_pending,
   output logic              dispatch_stall,
   output logic              take_strobe,
   output logic [ADDR_W-1:0] redirect_addr
);
   localparam logic [ADDR_W-1:0] EXP_LO = LOW_BASE + VEC_OFFSET;
   localparam logic [ADDR_W-1:0] EXP_HI = HIGH_BASE + VEC_OFFSET;

   logic req_live;
   logic draining;
   logic ready;
   logic load_vec;

   assign req_live = irq_req && msr_ee;

   eis_drain_qual #(.EMPTY_HOLD(EMPTY_HOLD)) u_qual (
      .clk            (clk),
      .rst_n          (rst_n),
      .draining       (draining),
      .cb_empty       (cb_empty),
      .hp_exc_pending (hp_exc_pending),
      .ready          (ready)
   );

   eis_ctrl_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_live (req_live),
      .ready    (ready),
      .cb_empty (cb_empty),
      .draining (draining),
      .load_vec (load_vec),
      .stall    (dispatch_stall),
      .take     (take_strobe)
   );

   eis_vector_gen #(
      .ADDR_W     (ADDR_W),
      .LOW_BASE   (LOW_BASE),
      .HIGH_BASE  (HIGH_BASE),
      .VEC_OFFSET (VEC_OFFSET)
   ) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vec),
      .msr_ip   (msr_ip),
      .vec_addr (redirect_addr)
   );

   assert_stall_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dispatch_stall && irq_req && msr_ee) |=> (dispatch_stall && !take_strobe));

   assert_take_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_strobe |-> $past(dispatch_stall && irq_req && msr_ee && cb_empty && !hp_exc_pending));

   assert_hp_delays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hp_exc_pending |=> !take_strobe);

   assert_disabled_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !msr_ee |=> !take_strobe);

   assert_request_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dispatch_stall && !take_strobe && !irq_req) |=> !dispatch_stall);

   assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take_strobe |-> (redirect_addr == ($past(msr_ip) ? EXP_HI : EXP_LO)));

endmodule

// File: tb/eis_ext_irq_seq_tb.sv
`timescale 1ns/1ps
module eis_ext_irq_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq_req, msr_ee, msr_ip, cb_empty, hp_exc_pending;
   logic        dispatch_stall, take_strobe;
   logic [31:0] redirect_addr;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   eis_ext_irq_seq dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .irq_req        (irq_req),
      .msr_ee         (msr_ee),
      .msr_ip         (msr_ip),
      .cb_empty       (cb_empty),
      .hp_exc_pending (hp_exc_pending),
      .dispatch_stall (dispatch_stall),
      .take_strobe    (take_strobe),
      .redirect_addr  (redirect_addr)
   );

   function automatic logic [31:0] exp_vec(input logic ip);
      return ip ? 32'hFFF0_0500 : 32'h0000_0500;
   endfunction

   // Bench model of the requirements: 0 idle, 1 draining, 2 taking
   int          m_st;
   logic [31:0] m_vec;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st <= 0;
      end else begin
         case (m_st)
            0: if (irq_req && msr_ee) m_st <= 1;
            1: begin
               if (!(irq_req && msr_ee)) m_st <= 0;
               else if (cb_empty && !hp_exc_pending) begin
                  m_st  <= 2;
                  m_vec <= exp_vec(msr_ip);
               end
            end
            default: m_st <= 0;
         endcase
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic rq, input logic ee, input logic ip,
                        input logic ce, input logic hp);
      irq_req = rq; msr_ee = ee; msr_ip = ip; cb_empty = ce; hp_exc_pending = hp;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      drive(0, 0, 0, 0, 0);
      repeat (3) tick();
      chk("R1 stall", {31'b0, dispatch_stall}, 0);
      chk("R1 take",  {31'b0, take_strobe}, 0);
      rst_n = 1'b1;

      // Long drain, low vector
      drive(1, 1, 0, 0, 0);
      tick();
      chk("R2 stall", {31'b0, dispatch_stall}, 1);
      chk("R2 take",  {31'b0, take_strobe}, 0);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R10 stall", {31'b0, dispatch_stall}, 1);
         chk("R10 take",  {31'b0, take_strobe}, 0);
      end
      cb_empty = 1;
      tick();
      chk("R3 take",  {31'b0, take_strobe}, 1);
      chk("R8 stall in take", {31'b0, dispatch_stall}, 1);
      chk("R9 low vector", redirect_addr, 32'h0000_0500);
      irq_req = 0;
      tick();
      chk("R7 take", {31'b0, take_strobe}, 0);
      chk("R8 release", {31'b0, dispatch_stall}, 0);

      // Higher-priority exception delays entry, high vector
      drive(1, 1, 1, 1, 1);
      tick();
      chk("R2 stall", {31'b0, dispatch_stall}, 1);
      tick();
      chk("R4 take", {31'b0, take_strobe}, 0);
      tick();
      chk("R4 take", {31'b0, take_strobe}, 0);
      chk("R4 stall", {31'b0, dispatch_stall}, 1);
      hp_exc_pending = 0;
      tick();
      chk("R3 take", {31'b0, take_strobe}, 1);
      chk("R9 high vector", redirect_addr, 32'hFFF0_0500);
      irq_req = 0;
      tick();

      // Enable clear keeps the request pending
      drive(1, 0, 0, 1, 0);
      tick();
      chk("R5 stall", {31'b0, dispatch_stall}, 0);
      chk("R5 take",  {31'b0, take_strobe}, 0);
      msr_ee = 1; cb_empty = 0;
      tick();
      chk("R5 stall", {31'b0, dispatch_stall}, 1);
      msr_ee = 0;
      tick();
      chk("R5 release", {31'b0, dispatch_stall}, 0);
      msr_ee = 1;
      tick();
      chk("R5 resume", {31'b0, dispatch_stall}, 1);
      cb_empty = 1;
      tick();
      chk("R5 take", {31'b0, take_strobe}, 1);
      irq_req = 0;
      tick();

      // Request dropped during drain
      drive(1, 1, 0, 0, 0);
      tick();
      chk("R6 stall", {31'b0, dispatch_stall}, 1);
      irq_req = 0;
      tick();
      chk("R6 stall", {31'b0, dispatch_stall}, 0);
      chk("R6 take",  {31'b0, take_strobe}, 0);
      tick();
      chk("R6 idle", {31'b0, dispatch_stall}, 0);

      // Constrained random against the bench model
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 8) == 0) irq_req = ~irq_req;
         msr_ee         = (($urandom % 10) != 0);
         cb_empty       = (($urandom % 3) == 0);
         hp_exc_pending = (($urandom % 6) == 0);
         if (($urandom % 32) == 0) msr_ip = ~msr_ip;
         tick();
         chk("R10 stall", {31'b0, dispatch_stall}, {31'b0, m_st != 0});
         chk("R3 take",   {31'b0, take_strobe},    {31'b0, m_st == 2});
         if (m_st == 2) chk("R9 vector", redirect_addr, m_vec);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule